// File: doc/BRIEF.md
# MDIO Clause 22 Gateway Master

This block is a management-bus master that issues clause 22 read and write frames on an MDC/MDIO pair. Software talks to it through two 32-bit words on a small register port: a gateway word at byte offset 0x0 and a configuration word at byte offset 0x4. Software launches a transaction by writing a command with the busy bit set into the gateway word. It then polls that bit until the hardware clears it. After a read, the low half of the gateway word holds the value the PHY returned. Writing all zeros to the gateway word during a transaction cancels the transaction.

The core clock is divided down to produce MDC. The configuration word sets the length of an MDC period. It also sets the core-clock cycle inside each period at which the master updates MDIO, and the cycle at which it samples MDIO. MDIO leaves the block as a data bit plus an output enable, and the pad tri-state sits outside the block.

Top module: `mdio_gw_master`

## Requirements
- R1: After reset, both words read as zero, MDC is low and the MDIO output enable is low.
- R2: The gateway word reads back with data in bits 15:0, register address in 20:16, PHY address in 25:21, opcode in 27:26, start in 28 and busy in 30; bits 29 and 31 read zero. The configuration word keeps bits 1:0, 2, 4 and 31:8 and reads zero elsewhere, so writing all ones reads back as 0xFFFFFF17.
- R3: A gateway write made while idle stores all fields, and it starts a frame only if bit 30 is 1. Busy reads 1 from the cycle after that write until the frame's last MDC period ends, and then reads 0.
- R4: With period value P (config bits 15:8), every MDC period is 2*(P+1) core cycles, with MDC high for P+1 of them. P=0 gives a 2-cycle MDC.
- R5: One bit is sent per MDC period, MSB first, and it is valid at the MDC rising edge. The frame is 32 ones, then 0,1, then the 2-bit opcode, the 5-bit PHY address and the 5-bit register address. A write frame continues with 1,0 and the 16 data bits. Opcode 2'b10 selects a read and any other value a write. Each frame has exactly 64 MDC pulses.
- R6: In a read frame the output enable is low from the first turnaround period to the end of the frame. The 16 sampled bits, first sample as bit 15, appear in gateway bits 15:0 once busy clears.
- R7: Counting core cycles in an MDC period from 0 at the first low cycle, MDIO data and enable change only in the cycle after count == output point (config bits 31:24).
- R8: MDIO input is captured on the core clock edge that ends count == input point (config bits 23:16), once per data period.
- R9: A nonzero gateway write while busy is 1 is ignored: the frame continues unchanged and the stored fields keep their values.
- R10: A gateway write of zero while busy is 1 clears busy from the next cycle. In that same cycle MDC is low and the output enable is low, and the stored fields are kept.
- R11: While busy is 0, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset: 0 gateway, 4 configuration |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the word selected by reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO level seen at the pad |

## Verification
The bench aims at the sample and update points. It moves the input point from after the MDC rising edge to before it and expects the read result shifted by one bit; a design sampling at a fixed phase would return the same value both times. It runs the fastest divider (P=0), where an off-by-one in the period counter shows up as a 1- or 3-cycle MDC. It cancels a read during turnaround and then runs a clean frame, which catches a design that leaves the counters or enable live after the cancel. It also writes a different command mid-frame, which exposes a design that re-latches fields while busy.

// File: rtl/mdio_gw_pkg.sv
// Shared types and constants for the MDIO gateway master.
// Assumes clause 22 framing with 5-bit addresses and 16-bit data.
package mdio_gw_pkg;
    localparam int DATA_W = 16;
    localparam int ADR_W  = 5;
    localparam int PT_W   = 8;
    localparam int PH_W   = PT_W + 1;

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    // Gateway fields packed so that they map onto bits 28:0 of the word.
    typedef struct packed {
        logic              st;
        logic [1:0]        op;
        logic [ADR_W-1:0]  phy;
        logic [ADR_W-1:0]  regad;
        logic [DATA_W-1:0] data;
    } gw_t;

    typedef struct packed {
        logic [PT_W-1:0] out_pt;
        logic [PT_W-1:0] in_pt;
        logic [PT_W-1:0] period;
        logic            full_drv;
        logic            sig33;
        logic [1:0]      mode;
    } cfg_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator and frame sequencer.
// A phase counter spans one whole MDC period (2*(period+1) cycles);
// MDC is low for the first half and high for the second. A slot counter
// advances once per period. Strobes mark the programmed output and input
// points. Assumes out_pt and in_pt are below 2*(period+1).
module mdio_mdc_gen
    import mdio_gw_pkg::*;
#(
    parameter int SLOTS  = 64,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PT_W-1:0]   period,
    input  logic [PT_W-1:0]   out_pt,
    input  logic [PT_W-1:0]   in_pt,
    output logic              mdc,
    output logic              out_stb,
    output logic              in_stb,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_done
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] ph_last;

    assign ph_last = {period, 1'b1};

    // Purpose: advance the phase counter and the slot counter while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph   <= '0;
            slot <= '0;
        end else if (ph == ph_last) begin
            ph <= '0;
            if (slot != LAST_SLOT) slot <= slot + 1'b1;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    // Purpose: decode the MDC level, the sample strobes and the end of the frame.
    always_comb begin
        mdc        = run && (ph > {1'b0, period});
        out_stb    = run && (ph == {1'b0, out_pt});
        in_stb     = run && (ph == {1'b0, in_pt});
        frame_done = run && (ph == ph_last) && (slot == LAST_SLOT);
    end

    // R4: MDC rises after exactly period+1 low cycles.
    a_r4_rise_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ph == {1'b0, period} + 1'b1);
    // R4: a falling MDC during a frame starts a new period at phase 0.
    a_r4_fall_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mdc) && run) |-> ph == '0);
endmodule

// File: rtl/mdio_frame_io.sv
// MDIO bit engine. Selects the frame bit for the current slot and
// registers it at the output point. It releases MDIO for the turnaround and
// data of a read, and shifts in the read data at the input point.
// Outputs are gated by run, so they drop as soon as the frame ends.
module mdio_frame_io
    import mdio_gw_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int SLOTS   = PRE_LEN + 32,
    parameter int SLOT_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              out_stb,
    input  logic              in_stb,
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        op,
    input  logic [ADR_W-1:0]  phy,
    input  logic [ADR_W-1:0]  regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_next
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] TA_SLOT   = SLOT_W'(SLOTS - DATA_W - 2);
    localparam logic [SLOT_W-1:0] DAT_SLOT  = SLOT_W'(SLOTS - DATA_W);

    logic [SLOTS-1:0]  frame_vec;
    logic              is_rd;
    logic              released;
    logic              cur_bit;
    logic              cap;
    logic              o_q;
    logic              oe_q;
    logic [DATA_W-1:0] shift_q;

    // Purpose: build the frame image and pick the bit and enable for this slot.
    always_comb begin
        frame_vec = {{PRE_LEN{1'b1}}, 2'b01, op, phy, regad, 2'b10, wdata};
        is_rd     = (op == OP_RD);
        released  = is_rd && (slot >= TA_SLOT);
        cur_bit   = frame_vec[LAST_SLOT - slot];
        cap       = in_stb && is_rd && (slot >= DAT_SLOT);
        rd_next   = cap ? {shift_q[DATA_W-2:0], mdio_i} : shift_q;
    end

    // Purpose: update the MDIO data and enable only at the output point.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            o_q  <= 1'b0;
            oe_q <= 1'b0;
        end else if (out_stb) begin
            o_q  <= cur_bit;
            oe_q <= !released;
        end
    end

    // Purpose: shift read data in at the input point during data slots.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) shift_q <= '0;
        else                shift_q <= rd_next;
    end

    assign mdio_o  = run && o_q;
    assign mdio_oe = run && oe_q;

    // R7: driven data and enable hold between output points.
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !out_stb) |=> (!run || ($stable(o_q) && $stable(oe_q))));
    // R6: MDIO stays released from the second turnaround slot onward in a read.
    a_r6_released: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_rd && slot > TA_SLOT) |-> !mdio_oe);
endmodule

// File: rtl/mdio_gw_master.sv
// MDIO clause 22 gateway master, top level.
// Holds the gateway and configuration words, launches a frame when a
// command with busy set is written while idle, and cancels it on a zero
// write. The read result is taken into the data field at completion.
// Assumes configuration is not changed while a frame runs.
module mdio_gw_master
    import mdio_gw_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int SLOTS  = PRE_LEN + 32;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [ADDR_W-1:0] GW_OFS  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CFG_OFS = ADDR_W'(4);

    gw_t               gw_q;
    cfg_t              cfg_q;
    logic              busy_q;
    logic              wr_gw;
    logic              wr_cfg;
    logic              out_stb;
    logic              in_stb;
    logic              frame_done;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] rd_next;

    assign wr_gw  = reg_wr && (reg_addr == GW_OFS);
    assign wr_cfg = reg_wr && (reg_addr == CFG_OFS);

    // Purpose: gateway word, busy flag, launch, cancel and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gw_q   <= '0;
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (frame_done) begin
                busy_q <= 1'b0;
                if (gw_q.op == OP_RD) gw_q.data <= rd_next;
            end else if (wr_gw && reg_wdata == 32'd0) begin
                busy_q <= 1'b0;
            end
        end else if (wr_gw) begin
            gw_q   <= gw_t'(reg_wdata[28:0]);
            busy_q <= reg_wdata[30];
        end
    end

    // Purpose: configuration word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q.out_pt   <= reg_wdata[31:24];
            cfg_q.in_pt    <= reg_wdata[23:16];
            cfg_q.period   <= reg_wdata[15:8];
            cfg_q.full_drv <= reg_wdata[4];
            cfg_q.sig33    <= reg_wdata[2];
            cfg_q.mode     <= reg_wdata[1:0];
        end
    end

    // Purpose: read mux for the two words.
    always_comb begin
        if (reg_addr == GW_OFS)
            reg_rdata = {1'b0, busy_q, 1'b0, gw_q};
        else if (reg_addr == CFG_OFS)
            reg_rdata = {cfg_q.out_pt, cfg_q.in_pt, cfg_q.period, 3'b000,
                         cfg_q.full_drv, 1'b0, cfg_q.sig33, cfg_q.mode};
        else
            reg_rdata = 32'd0;
    end

    mdio_mdc_gen #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy_q),
        .period     (cfg_q.period),
        .out_pt     (cfg_q.out_pt),
        .in_pt      (cfg_q.in_pt),
        .mdc        (mdc),
        .out_stb    (out_stb),
        .in_stb     (in_stb),
        .slot       (slot),
        .frame_done (frame_done)
    );

    mdio_frame_io #(
        .PRE_LEN (PRE_LEN),
        .SLOTS   (SLOTS),
        .SLOT_W  (SLOT_W)
    ) u_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy_q),
        .out_stb (out_stb),
        .in_stb  (in_stb),
        .slot    (slot),
        .op      (gw_q.op),
        .phy     (gw_q.phy),
        .regad   (gw_q.regad),
        .wdata   (gw_q.data),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_next (rd_next)
    );

    // R11: idle bus keeps MDC low and MDIO released.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (!mdc && !mdio_oe));
    // R3: a launch command while idle raises busy.
    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && wr_gw && reg_wdata[30]) |=> busy_q);
    // R3: the end of the last MDC period clears busy.
    a_r3_complete: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !busy_q);
    // R9: nonzero writes while busy change nothing.
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_gw && reg_wdata != 32'd0 && !frame_done)
        |=> (busy_q && gw_q == $past(gw_q)));
    // R10: a zero write while busy cancels at once.
    a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_gw && reg_wdata == 32'd0 && !frame_done)
        |=> (!busy_q && !mdc && !mdio_oe && gw_q == $past(gw_q)));
endmodule

// File: tb/sim_mdio_gw_master.sv
// Scoreboard bench: the driver pushes the expected per-period MDIO state,
// a monitor pops and compares at each MDC rising edge and also plays the PHY.
module sim_mdio_gw_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    always #5 clk = ~clk;

    mdio_gw_master u0 (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .mdc (mdc),
        .mdio_o (mdio_o), .mdio_oe (mdio_oe), .mdio_i (mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard and monitor state.
    logic [2:0]  exp_q[$];
    logic [2:0]  e;
    int          cP = 0, cOut = 0;
    int          rises = 0, cyc = 0, hi = 0, bph = 0;
    bit          bvalid = 0, skip = 0, phy_rd = 0;
    logic [15:0] phy_val = 16'h0;
    logic        pm = 1'b0;
    logic [1:0]  pout = 2'b00;

    // Monitor: compares at MDC rising edges, checks period and change point, drives PHY data.
    always @(negedge clk) begin
        if (rst_n) begin
            int s;
            cyc++;
            if (mdc) hi++;
            if (mdc && !pm) begin
                if (!skip) begin
                    if (rises > 0) chk("R4 MDC period", cyc, 2 * (cP + 1));
                    if (exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        chk("R5/R6 enable at rise", {31'd0, mdio_oe}, {31'd0, e[1]});
                        if (e[2]) chk("R5 bit at rise", {31'd0, mdio_o}, {31'd0, e[0]});
                    end else begin
                        chk("R5 extra MDC pulse", 32'd1, 32'd0);
                    end
                end
                cyc = 0;
                s = rises;
                rises++;
                if (phy_rd && s >= 48 && s <= 63) mdio_i = phy_val[63 - s];
            end
            if (!mdc && pm) begin
                if (!skip) chk("R4 MDC high length", hi, cP + 1);
                hi = 0;
                bph = 0;
                bvalid = 1;
            end else begin
                bph++;
            end
            if (bvalid && !skip && {mdio_oe, mdio_o} != pout && !(rises == 64 && !mdc))
                chk("R7 change point", bph, cOut + 1);
            pm = mdc;
            pout = {mdio_oe, mdio_o};
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_cfg(input int p, input int o, input int i);
        cP = p; cOut = o;
        reg_write(3'd4, (32'(o) << 24) | (32'(i) << 16) | (32'(p) << 8));
    endtask

    function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] ph,
                                           input logic [4:0] rg, input logic [15:0] d);
        return (32'd1 << 30) | (32'd1 << 28) | (32'(op) << 26) | (32'(ph) << 21)
             | (32'(rg) << 16) | 32'(d);
    endfunction

    // Driver: push the expected 64 periods, then issue the command.
    task automatic launch(input logic [1:0] op, input logic [4:0] ph, input logic [4:0] rg,
                          input logic [15:0] d, input logic [15:0] pv);
        logic [63:0] v;
        v = {32'hFFFF_FFFF, 2'b01, op, ph, rg, 2'b10, d};
        for (int s = 0; s < 64; s++) begin
            bit rel;
            rel = (op == 2'b10) && (s >= 46);
            exp_q.push_back({!rel, !rel, rel ? 1'b0 : v[63 - s]});
        end
        phy_rd = (op == 2'b10);
        phy_val = pv;
        mdio_i = 1'b0;
        rises = 0; bvalid = 0; cyc = 0; hi = 0;
        reg_write(3'd0, mk_cmd(op, ph, rg, d));
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        for (int k = 0; k < 30000; k++) begin
            reg_read(3'd0, v);
            if (!v[30]) return;
        end
        chk({req, " busy never cleared"}, 32'd1, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(3'd0, v); chk("R1 gateway reset", v, 32'd0);
        reg_read(3'd4, v); chk("R1 config reset", v, 32'd0);
        chk("R1 mdc low", {31'd0, mdc}, 32'd0);
        chk("R1 oe low", {31'd0, mdio_oe}, 32'd0);

        // R2: field layout readback
        reg_write(3'd4, 32'hFFFF_FFFF);
        reg_read(3'd4, v); chk("R2 config layout", v, 32'hFFFF_FF17);
        reg_write(3'd0, 32'hBFFF_FFFF);
        reg_read(3'd0, v); chk("R2 gateway layout", v, 32'h1FFF_FFFF);
        // R3/R11: no busy bit means no frame
        repeat (50) @(negedge clk);
        chk("R11 idle mdc", {31'd0, mdc}, 32'd0);
        chk("R11 idle oe", {31'd0, mdio_oe}, 32'd0);
        reg_read(3'd0, v); chk("R3 no launch without busy", {31'd0, v[30]}, 32'd0);

        // R5 write frame with R9 ignored writes mid-frame
        set_cfg(15, 2, 20);
        launch(2'b01, 5'h13, 5'h0A, 16'hA5C3, 16'h0);
        reg_read(3'd0, v); chk("R3 busy after launch", {31'd0, v[30]}, 32'd1);
        repeat (300) @(negedge clk);
        reg_write(3'd0, 32'hC7FF_FFFF);
        reg_write(3'd0, 32'h0000_1234);
        wait_idle("R3");
        chk("R5 all periods seen", exp_q.size(), 32'd0);
        reg_read(3'd0, v);
        chk("R9 fields kept", v, mk_cmd(2'b01, 5'h13, 5'h0A, 16'hA5C3) & ~(32'd1 << 30));

        // R6 read frame, input point after the rising edge
        launch(2'b10, 5'h01, 5'h02, 16'h0, 16'h3C69);
        wait_idle("R6");
        chk("R6 all periods seen", exp_q.size(), 32'd0);
        reg_read(3'd0, v); chk("R6 read data", v, mk_cmd(2'b10, 5'h01, 5'h02, 16'h3C69) & ~(32'd1 << 30));

        // R8 input point before the rising edge: result lags one bit
        set_cfg(15, 2, 5);
        launch(2'b10, 5'h1F, 5'h11, 16'h0, 16'hB00F);
        wait_idle("R8");
        reg_read(3'd0, v); chk("R8 early sample point", {16'd0, v[15:0]}, 32'h0000_5807);

        // R4 fastest divider, write then read
        set_cfg(0, 0, 1);
        launch(2'b01, 5'h00, 5'h1F, 16'h5A5A, 16'h0);
        wait_idle("R4");
        chk("R4 fast write periods", exp_q.size(), 32'd0);
        launch(2'b10, 5'h0C, 5'h03, 16'h0, 16'h8001);
        wait_idle("R4");
        reg_read(3'd0, v); chk("R4 fast read data", {16'd0, v[15:0]}, 32'h0000_8001);

        // R4 typical slow setting
        set_cfg(85, 13, 6);
        launch(2'b01, 5'h05, 5'h04, 16'hFFFF, 16'h0);
        wait_idle("R4");
        chk("R4 slow write periods", exp_q.size(), 32'd0);

        // R10 cancel during a read turnaround, then recover
        set_cfg(15, 2, 20);
        launch(2'b10, 5'h07, 5'h09, 16'h0, 16'h1234);
        repeat (1500) @(negedge clk);
        skip = 1;
        reg_write(3'd0, 32'd0);
        chk("R10 mdc low after cancel", {31'd0, mdc}, 32'd0);
        chk("R10 oe low after cancel", {31'd0, mdio_oe}, 32'd0);
        reg_read(3'd0, v);
        chk("R10 busy clear, fields kept", v, mk_cmd(2'b10, 5'h07, 5'h09, 16'h0) & ~(32'd1 << 30));
        repeat (100) @(negedge clk);
        chk("R10 bus stays idle", {30'd0, mdc, mdio_oe}, 32'd0);
        exp_q.delete();
        skip = 0;
        launch(2'b01, 5'h15, 5'h0E, 16'h0F0F, 16'h0);
        wait_idle("R10");
        chk("R10 clean frame after cancel", exp_q.size(), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule